// File: doc/BRIEF.md
# Multi-Format Page Table Walker

This block turns a virtual address into a finished translation by reading page table entries one level at a time over a single request/response memory port. The paging format is fixed when a walk is launched, from three control inputs. With the long-mode input set it walks four levels of 8-byte entries. With the extended-address input set it walks a 4-entry pointer table and then two levels of 8-byte entries. Otherwise it walks two levels of 4-byte entries, and with the large-page input set a directory entry may map a 4 MB page directly.

While it walks, the block merges the write and user permissions of every level that carries them. It also writes back, with the accessed bit set, each entry it read whose accessed bit was clear. A finished walk gives a one-cycle `done` pulse. On that pulse the block either offers the translation (virtual and physical base, page size, permissions, cache attributes) to a TLB insert port, or reports a fault code. The memory side is a valid/ready request channel. Reads get exactly one response, and writes complete when they are accepted.

Top module: `pt_walker`

## Requirements
- R1: When `mode_long` is set, the first read is at `{root[51:12],12'h000} + va[47:39]*8`. The walk then reads three more levels, indexed by va[38:30], va[29:21] and va[20:12]. `ins_size` encodes 0=4 KB, 1=2 MB, 2=4 MB.
- R2: When only `mode_pae` is set, the first read is at `{root[31:5],5'b0} + va[31:30]*8`. For that pointer entry only the present bit (bit 0) is examined. It carries no permissions, is never checked for NX and is never written back. The next two levels are indexed by va[29:21] and va[20:12].
- R3: With neither mode set, requests have `req_wide`=0 and only rsp_data[31:0] is used. The first read is at `{root[31:12],12'h000} + va[31:22]*4`, and the table read is at base + va[21:12]*4. The directory bit 7 is ignored unless `mode_pse` is set.
- R4: The next-level base is entry bits 51:12 for 8-byte entries and bits 31:12 for 4-byte entries, with the low 12 bits zero.
- R5: In the long and extended formats, a directory-level entry (the level above the last) with bit 7 set ends the walk as a 2 MB page. The page base is entry bits 51:21, and `ins_vbase` is va with bits 20:0 cleared.
- R6: In the large-page legacy format, a directory entry with bit 7 set ends the walk as a 4 MB page. Physical bits 31:22 come from entry bits 31:22, physical bits 39:32 come from entry bits 20:13, and `ins_vbase` has bits 21:0 cleared.
- R7: `ins_wr` (bit 1) and `ins_user` (bit 2) are the AND over every level that carries permissions, starting at the first such level. `ins_nx` is the OR of bit 63 over those levels.
- R8: An entry whose accessed bit (bit 5) is clear is written back to its own address with bit 5 set. The next table read is always requested before that write.
- R9: A clear present bit gives `fault`=1. A set bit 63 gives `fault`=2 unless both `nx_support` and `nx_enable` are set. A faulting walk never raises `ins_valid`.
- R10: The PAT attribute comes from bit 12 for large pages and from bit 7 for 4 KB leaf entries. `ins_ucd` is leaf bit 4 and `ins_glb` is leaf bit 8.
- R11: A request not accepted (`req_ready` low) stays asserted with the same address and direction until it is accepted.
- R12: After reset `busy`, `done` and `req_valid` are low. `done` is a one-cycle pulse, and the block is idle (`busy` low) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a walk when idle |
| mode_long | input | 1 | Select the four-level 8-byte format |
| mode_pae | input | 1 | Select the pointer-table 8-byte format (when mode_long is low) |
| mode_pse | input | 1 | Allow 4 MB pages in the 4-byte format |
| nx_support | input | 1 | No-execute bit is implemented |
| nx_enable | input | 1 | No-execute bit is enabled |
| root | input | PA_W | Root table register value |
| va | input | VA_W | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | Request is an accessed-bit write-back |
| req_wide | output | 1 | 1: 8-byte access, 0: 4-byte access |
| req_addr | output | PA_W | Request byte address |
| req_wdata | output | 64 | Write-back data |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 2 | 0 none, 1 not present, 2 no-execute |
| ins_valid | output | 1 | TLB insert strobe |
| ins_vbase | output | VA_W | Page-aligned virtual base |
| ins_pbase | output | PA_W | Page-aligned physical base |
| ins_size | output | 2 | 0 4 KB, 1 2 MB, 2 4 MB |
| ins_wr | output | 1 | Merged write permission |
| ins_user | output | 1 | Merged user permission |
| ins_nx | output | 1 | Merged no-execute |
| ins_ucd | output | 1 | Uncacheable attribute of the leaf |
| ins_glb | output | 1 | Global attribute of the leaf |
| ins_pat | output | 1 | PAT attribute of the leaf |

## Verification
A corrupted level counter or format register shows up on the very next read request, as a wrong index field or a wrong entry width in `req_addr`/`req_wide`. The bench therefore compares every request address in order, not just the final result. A stuck or lost write-back flag shows up within a few cycles, either as a write that never appears or as one issued ahead of the next read. Permission and attribute accumulation errors stay hidden until the `done` pulse, where they appear as wrong `ins_*` fields. The table vectors use different values at each level so that a wrong merge rule cannot match by chance.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W = 48,
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mode_long,
  input  logic            mode_pae,
  input  logic            mode_pse,
  input  logic            nx_support,
  input  logic            nx_enable,
  input  logic [PA_W-1:0] root,
  input  logic [VA_W-1:0] va,
  output logic            busy,
  output logic            req_valid,
  input  logic            req_ready,
  output logic            req_write,
  output logic            req_wide,
  output logic [PA_W-1:0] req_addr,
  output logic [63:0]     req_wdata,
  input  logic            rsp_valid,
  input  logic [63:0]     rsp_data,
  output logic            done,
  output logic [1:0]      fault,
  output logic            ins_valid,
  output logic [VA_W-1:0] ins_vbase,
  output logic [PA_W-1:0] ins_pbase,
  output logic [1:0]      ins_size,
  output logic            ins_wr,
  output logic            ins_user,
  output logic            ins_nx,
  output logic            ins_ucd,
  output logic            ins_glb,
  output logic            ins_pat
);
  localparam logic [1:0] SZ_4K = 2'd0, SZ_2M = 2'd1, SZ_4M = 2'd2;
  localparam logic [1:0] FLT_NONE = 2'd0, FLT_NP = 2'd1, FLT_NX = 2'd2;

  typedef enum logic [1:0] {F_LONG, F_PAE, F_PSE, F_LEG} fmt_t;
  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_EVAL, S_FLUSH, S_DONE} st_t;

  st_t             st;
  fmt_t            fmt;
  logic [1:0]      lvl;
  logic [PA_W-1:0] cur, wb_addr;
  logic [63:0]     ent, wb_data;
  logic            wb_pend;
  logic [VA_W-1:0] va_r;
  logic            nx_ok, fresh, acc_w, acc_u, acc_nx;
  logic [1:0]      fault_r, size_r;
  logic [PA_W-1:0] pbase_r;
  logic            ucd_r, glb_r, pat_r;

  // byte offset of the entry selected by va bits 47:12 at a given level
  function automatic logic [PA_W-1:0] offs(fmt_t f, logic [1:0] l, logic [35:0] u);
    if (f == F_PSE || f == F_LEG)
      return (l == 2'd1) ? PA_W'({u[19:10], 2'b00}) : PA_W'({u[9:0], 2'b00});
    case (l)
      2'd3:    return PA_W'({u[35:27], 3'b000});
      2'd2:    return (f == F_PAE) ? PA_W'({u[19:18], 3'b000}) : PA_W'({u[26:18], 3'b000});
      2'd1:    return PA_W'({u[17:9], 3'b000});
      default: return PA_W'({u[8:0], 3'b000});
    endcase
  endfunction

  fmt_t            s_fmt;
  logic [1:0]      s_lvl;
  logic [PA_W-1:0] s_base;
  assign s_fmt  = mode_long ? F_LONG : mode_pae ? F_PAE : mode_pse ? F_PSE : F_LEG;
  assign s_lvl  = mode_long ? 2'd3 : mode_pae ? 2'd2 : 2'd1;
  assign s_base = mode_long ? {root[PA_W-1:12], 12'h000} :
                  mode_pae  ? PA_W'({root[31:5], 5'b0}) : PA_W'({root[31:12], 12'h000});

  wire narrow  = fmt[1];
  wire carries = !(fmt == F_PAE && lvl == 2'd2);
  wire big     = (lvl == 2'd1) && ent[7] && (fmt != F_LEG);
  wire leaf    = (lvl == 2'd0) || big;
  wire needwb  = carries && !ent[5];
  wire [PA_W-1:0] nbase = narrow ? PA_W'({ent[31:12], 12'h000}) : {ent[PA_W-1:12], 12'h000};
  wire [PA_W-1:0] lpage = (fmt == F_PSE) ? PA_W'({ent[20:13], ent[31:22], 22'h0})
                                         : {ent[PA_W-1:21], 21'h0};
  wire wr_acc = req_valid && req_ready && req_write;
  wire unused_bits = ^{ent[62:PA_W], ent[11:9], ent[6], ent[3], va_r[11:0], root[4:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; fmt <= F_LONG; lvl <= 2'd0; cur <= '0; va_r <= '0; ent <= '0;
      wb_pend <= 1'b0; wb_addr <= '0; wb_data <= '0;
      nx_ok <= 1'b0; fresh <= 1'b1; acc_w <= 1'b0; acc_u <= 1'b0; acc_nx <= 1'b0;
      fault_r <= FLT_NONE; size_r <= SZ_4K; pbase_r <= '0;
      ucd_r <= 1'b0; glb_r <= 1'b0; pat_r <= 1'b0;
    end else begin
      if (wr_acc) wb_pend <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          fmt <= s_fmt; lvl <= s_lvl; va_r <= va;
          cur <= s_base + offs(s_fmt, s_lvl, va[47:12]);
          nx_ok <= nx_support & nx_enable; fresh <= 1'b1; fault_r <= FLT_NONE;
          st <= S_RD;
        end
        S_RD:   if (req_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          ent <= narrow ? {32'h0, rsp_data[31:0]} : rsp_data;
          st  <= S_EVAL;
        end
        S_EVAL: if (!wb_pend) begin
          if (!ent[0]) begin
            fault_r <= FLT_NP; st <= S_DONE;
          end else if (carries && ent[63] && !nx_ok) begin
            fault_r <= FLT_NX; st <= S_DONE;
          end else begin
            if (carries) begin
              acc_w  <= fresh ? ent[1]  : acc_w & ent[1];
              acc_u  <= fresh ? ent[2]  : acc_u & ent[2];
              acc_nx <= fresh ? ent[63] : acc_nx | ent[63];
              fresh  <= 1'b0;
            end
            if (needwb) begin
              wb_pend <= 1'b1; wb_addr <= cur; wb_data <= ent | 64'h20;
            end
            if (leaf) begin
              pbase_r <= big ? lpage : nbase;
              size_r  <= big ? ((fmt == F_PSE) ? SZ_4M : SZ_2M) : SZ_4K;
              pat_r   <= big ? ent[12] : ent[7];
              ucd_r   <= ent[4];
              glb_r   <= ent[8];
              st      <= needwb ? S_FLUSH : S_DONE;
            end else begin
              cur <= nbase + offs(fmt, lvl - 2'd1, va_r[47:12]);
              lvl <= lvl - 2'd1;
              st  <= S_RD;
            end
          end
        end
        S_FLUSH: if (!wb_pend) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign fault     = fault_r;
  assign ins_valid = done && (fault_r == FLT_NONE);
  assign req_valid = (st == S_RD) || wb_pend;
  assign req_write = (st != S_RD);
  assign req_wide  = !narrow;
  assign req_addr  = (st == S_RD) ? cur : wb_addr;
  assign req_wdata = (st == S_RD) ? 64'h0 : wb_data;
  assign ins_pbase = pbase_r;
  assign ins_size  = size_r;
  assign ins_vbase = (size_r == SZ_4K) ? {va_r[VA_W-1:12], 12'h0} :
                     (size_r == SZ_2M) ? {va_r[VA_W-1:21], 21'h0} : {va_r[VA_W-1:22], 22'h0};
  assign ins_wr    = acc_w;
  assign ins_user  = acc_u;
  assign ins_nx    = acc_nx;
  assign ins_ucd   = ucd_r;
  assign ins_glb   = glb_r;
  assign ins_pat   = pat_r;

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write));
  assert_wb_abit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> req_wdata[5]);
  assert_large_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_size == SZ_2M |-> ins_pbase[20:0] == 21'h0);
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic mode_long = 1'b0, mode_pae = 1'b0, mode_pse = 1'b0, nx_support = 1'b0, nx_enable = 1'b0;
  logic [51:0] root = '0;
  logic [47:0] va_i = '0;
  logic busy, req_valid, req_write, req_wide, done, ins_valid;
  logic ins_wr, ins_user, ins_nx, ins_ucd, ins_glb, ins_pat;
  logic [51:0] req_addr, ins_pbase;
  logic [63:0] req_wdata;
  logic [47:0] ins_vbase;
  logic [1:0]  fault, ins_size;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        hold = 1'b0, flip = 1'b0, tick = 1'b0, log_clr = 1'b0;
  logic        req_ready;
  int total = 0, bad = 0;

  always #2 clk = ~clk;
  always @(negedge clk) tick <= ~tick;
  assign req_ready = hold ? 1'b0 : (flip ? tick : 1'b1);

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_long(mode_long), .mode_pae(mode_pae),
    .mode_pse(mode_pse), .nx_support(nx_support), .nx_enable(nx_enable), .root(root), .va(va_i),
    .busy(busy), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .done(done), .fault(fault), .ins_valid(ins_valid), .ins_vbase(ins_vbase),
    .ins_pbase(ins_pbase), .ins_size(ins_size), .ins_wr(ins_wr), .ins_user(ins_user),
    .ins_nx(ins_nx), .ins_ucd(ins_ucd), .ins_glb(ins_glb), .ins_pat(ins_pat));

  // memory model: four address/data slots, one-cycle read latency, event log
  logic [63:0] mem_a [4];
  logic [63:0] mem_d [4];
  logic        ev_w [32];
  logic        ev_wide [32];
  logic [51:0] ev_a [32];
  logic [63:0] ev_d [32];
  logic [4:0]  ev_cnt = '0;

  function automatic logic [63:0] look(input logic [51:0] a);
    for (int k = 0; k < 4; k++) if (mem_a[k][51:0] == a) return mem_d[k];
    return 64'h0;
  endfunction

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (log_clr) ev_cnt <= '0;
    else if (rst_n && req_valid && req_ready) begin
      ev_w[ev_cnt] <= req_write; ev_a[ev_cnt] <= req_addr;
      ev_d[ev_cnt] <= req_wdata; ev_wide[ev_cnt] <= req_wide;
      if (ev_cnt != 5'd31) ev_cnt <= ev_cnt + 5'd1;
      if (!req_write) begin rsp_valid <= 1'b1; rsp_data <= look(req_addr); end
    end
  end

  // vector table: mode 0 long, 1 extended, 2 legacy+4MB, 3 legacy
  localparam int NV = 8;
  localparam logic [1:0]  T_MODE [NV] = '{0, 0, 1, 2, 3, 0, 0, 0};
  localparam logic        T_NX   [NV] = '{0, 0, 0, 0, 0, 0, 0, 1};
  localparam logic [63:0] T_ROOT [NV] = '{64'h1000, 64'h1000, 64'h0FE0, 64'h8000, 64'h9000,
                                          64'h1000, 64'h1000, 64'h1000};
  localparam logic [63:0] T_VA   [NV] = '{64'h80_8060_4123, 64'hA01234, 64'hC020_2055, 64'hC01234,
                                          64'h402007, 64'h0, 64'h0, 64'h0};
  localparam int          T_N    [NV] = '{4, 3, 3, 1, 2, 2, 1, 3};
  localparam logic [63:0] T_A [NV][4] = '{
    '{64'h1008, 64'h2010, 64'h3018, 64'h4020},
    '{64'h1000, 64'h2000, 64'h3028, 64'h1},
    '{64'h0FF8, 64'h5008, 64'h6010, 64'h1},
    '{64'h800C, 64'h1, 64'h1, 64'h1},
    '{64'h9004, 64'hA008, 64'h1, 64'h1},
    '{64'h1000, 64'h2000, 64'h1, 64'h1},
    '{64'h1000, 64'h1, 64'h1, 64'h1},
    '{64'h1000, 64'h2000, 64'h3000, 64'h1}};
  localparam logic [63:0] T_D [NV][4] = '{
    '{64'h2027, 64'h3027, 64'h4027, 64'hA_BCDE_F137},
    '{64'h2027, 64'h3023, 64'h4020_10A7, 64'h0},
    '{64'h5001, 64'h6027, 64'h70A5, 64'h0},
    '{64'h0040_A0A7, 64'h0, 64'h0, 64'h0},
    '{64'hA0A7, 64'hFFFF_FFFF_B000_00A7, 64'h0, 64'h0},
    '{64'h2027, 64'h3026, 64'h0, 64'h0},
    '{64'h8000_0000_0000_2027, 64'h0, 64'h0, 64'h0},
    '{64'h2027, 64'h3027, 64'h8000_0000_0020_00A7, 64'h0}};
  localparam logic [1:0]  T_F    [NV] = '{0, 0, 0, 0, 0, 1, 2, 0};
  localparam logic [63:0] T_PB   [NV] = '{64'hA_BCDE_F000, 64'h4020_0000, 64'h7000, 64'h5_0040_0000,
                                          64'hB000_0000, 64'h0, 64'h0, 64'h20_0000};
  localparam logic [63:0] T_VB   [NV] = '{64'h80_8060_4000, 64'hA00000, 64'hC020_2000, 64'hC00000,
                                          64'h402000, 64'h0, 64'h0, 64'h0};
  localparam logic [1:0]  T_SZ   [NV] = '{0, 1, 0, 2, 0, 0, 0, 1};
  localparam logic [1:0]  T_WU   [NV] = '{2'b11, 2'b10, 2'b01, 2'b11, 2'b11, 2'b00, 2'b00, 2'b11};
  localparam logic [3:0]  T_ATT  [NV] = '{4'b0110, 4'b1000, 4'b1000, 4'b0000, 4'b1000,
                                          4'b0000, 4'b0000, 4'b0001};

  function automatic string tag(input int i);
    case (i)
      0: return "R1 R4 R10";
      1: return "R1 R5 R7 R10";
      2: return "R2 R4 R7 R10";
      3: return "R3 R6";
      4: return "R3 R4 R10";
      5: return "R9";
      6: return "R9";
      default: return "R5 R7 R9";
    endcase
  endfunction

  task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] m, input logic nxb, input logic [63:0] rt, input logic [63:0] v);
    @(negedge clk);
    log_clr = 1'b1;
    mode_long = (m == 2'd0); mode_pae = (m == 2'd1); mode_pse = (m == 2'd2);
    nx_support = 1'b1; nx_enable = nxb; root = rt[51:0]; va_i = v[47:0];
    @(negedge clk); log_clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL R12 watchdog actual=0 expected=1");
    end
  endtask

  task automatic load(input logic [63:0] a0, d0, a1, d1);
    mem_a[0] = a0; mem_d[0] = d0; mem_a[1] = a1; mem_d[1] = d1;
    mem_a[2] = 64'h1; mem_d[2] = 64'h0; mem_a[3] = 64'h1; mem_d[3] = 64'h0;
  endtask

  initial begin
    load(64'h1, 64'h0, 64'h1, 64'h0);
    repeat (3) @(negedge clk);
    chk("R12", "reset busy", {63'h0, busy}, 64'h0);
    chk("R12", "reset done", {63'h0, done}, 64'h0);
    chk("R12", "reset req_valid", {63'h0, req_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 4; k++) begin mem_a[k] = T_A[i][k]; mem_d[k] = T_D[i][k]; end
      launch(T_MODE[i], T_NX[i], T_ROOT[i], T_VA[i]);
      wait_done();
      chk(tag(i), "fault", {62'h0, fault}, {62'h0, T_F[i]});
      chk(tag(i), "ins_valid", {63'h0, ins_valid}, {63'h0, T_F[i] == 2'd0});
      chk(tag(i), "request count", {59'h0, ev_cnt}, 64'(T_N[i]));
      for (int k = 0; k < T_N[i]; k++) begin
        chk(tag(i), "read address", {12'h0, ev_a[k]}, T_A[i][k]);
        chk(tag(i), "request is read", {63'h0, ev_w[k]}, 64'h0);
      end
      if (T_F[i] == 2'd0) begin
        chk(tag(i), "pbase", {12'h0, ins_pbase}, T_PB[i]);
        chk(tag(i), "vbase", {16'h0, ins_vbase}, T_VB[i]);
        chk(tag(i), "size", {62'h0, ins_size}, {62'h0, T_SZ[i]});
        chk(tag(i), "wr/user", {62'h0, ins_wr, ins_user}, {62'h0, T_WU[i]});
        chk(tag(i), "pat/ucd/glb/nx", {60'h0, ins_pat, ins_ucd, ins_glb, ins_nx}, {60'h0, T_ATT[i]});
      end
      @(negedge clk);
      chk("R12", "idle after done", {62'h0, busy, done}, 64'h0);
    end

    // accessed-bit write-backs, legacy 4-byte format; second pass with a toggling ready
    for (int pass = 0; pass < 2; pass++) begin
      flip = (pass == 1);
      load(64'h9000, 64'hA007, 64'hA000, 64'hB007);
      launch(2'd3, 1'b0, 64'h9000, 64'h0);
      wait_done();
      chk("R8", "event count", {59'h0, ev_cnt}, 64'd4);
      chk("R8", "order r,r,w,w", {60'h0, ev_w[0], ev_w[1], ev_w[2], ev_w[3]}, 64'b0011);
      chk("R8", "addr 0", {12'h0, ev_a[0]}, 64'h9000);
      chk("R8", "addr 1", {12'h0, ev_a[1]}, 64'hA000);
      chk("R8", "wb addr 2", {12'h0, ev_a[2]}, 64'h9000);
      chk("R8", "wb addr 3", {12'h0, ev_a[3]}, 64'hA000);
      chk("R8", "wb data 2", ev_d[2], 64'hA027);
      chk("R8", "wb data 3", ev_d[3], 64'hB027);
      chk("R3", "narrow requests", {60'h0, ev_wide[0], ev_wide[1], ev_wide[2], ev_wide[3]}, 64'h0);
      chk("R7", "wr/user", {62'h0, ins_wr, ins_user}, 64'b11);
      chk("R4", "pbase", {12'h0, ins_pbase}, 64'hB000);
      @(negedge clk);
    end
    flip = 1'b0;

    // refused request is held (R11)
    load(64'h800C, 64'h0040_A0A7, 64'h1, 64'h0);
    hold = 1'b1;
    launch(2'd2, 1'b0, 64'h8000, 64'hC01234);
    repeat (6) @(negedge clk);
    chk("R11", "held valid", {63'h0, req_valid}, 64'h1);
    chk("R11", "held addr", {12'h0, req_addr}, 64'h800C);
    chk("R11", "held direction", {63'h0, req_write}, 64'h0);
    chk("R11", "nothing accepted", {59'h0, ev_cnt}, 64'h0);
    hold = 1'b0;
    wait_done();
    chk("R11", "pbase after retry", {12'h0, ins_pbase}, 64'h5_0040_0000);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule